// File: doc/BRIEF.md
# Virtual Interrupt List-Register Interface

This block keeps a small bank of list registers that hypervisor software loads with virtual interrupts meant for one guest CPU. Each list entry names a virtual interrupt ID, the CPU ID of the source, a priority, a two-bit life-cycle state and a flag asking for a completion notice. The guest CPU works through a separate register port. It enables its virtual interface and sets a priority mask. It reads an acknowledge register to take the most urgent pending entry. It writes an end-of-interrupt register to retire an entry.

The hypervisor port reads and writes every list entry. It can also read a fixed type word and a combined machine-control word that holds the guest priority mask and the two binary-point fields. Two status summaries are derived from the entry states: a bitmap of empty entries and a bitmap of entries that completed while asking for notice. A single registered output raises the virtual interrupt request whenever the guest could take an entry.

Both ports are 32 bits wide and use byte addresses. Reads return data combinationally from the current address. Writes take effect at the rising clock edge. Reading the acknowledge register has a side effect, so the guest port carries a read strobe.

Top module: `virq_list_if`

## Requirements
- R1: List entry i sits at hypervisor address 0x80 + 4*i. Its word holds the virtual ID in bits [9:0], the CPU ID in [12:10], the notice flag in bit 19, the priority in [27:23] and the state in [29:28] (0 invalid, 1 pending, 2 active, 3 pending and active). Any other bit reads as zero, so writing 0xFFFFFFFF reads back 0x3F881FFF.
- R2: Hypervisor address 0x04 reads 0x44000000 OR (entry count − 1), and address 0x40 reads zero. Writes to either address change nothing.
- R3: Hypervisor address 0x08 holds the priority mask in [31:27], the binary point in [23:21] and the aliased binary point in [20:18]. Guest address 0x04 reads and writes the same mask in bits [4:0].
- R4: A guest read of address 0x0C returns 1023 and changes no state when the enable bit is clear or when no entry is eligible. An entry is eligible when its state is 1 or 3 and its priority is numerically below the mask.
- R5: Otherwise the acknowledge read returns the virtual ID in [9:0] and the CPU ID in [12:10] of the eligible entry with the lowest priority value. On a tie, the lowest index wins.
- R6: A strobed acknowledge read that returns an entry sets that entry's state to 2 (active).
- R7: A guest write to address 0x10 carries a virtual ID in [9:0] and a CPU ID in [12:10]. The lowest-index non-invalid entry that matches both fields has its state set to 0.
- R8: An end-of-interrupt write that matches no non-invalid entry changes no entry.
- R9: Hypervisor address 0x30 sets bit i exactly when entry i has state 0.
- R10: Hypervisor address 0x20 sets bit i exactly when entry i has state 0 and its notice flag set. Address 0x24, the upper half of this 64-bit status, reads zero for four entries.
- R11: The request output is a register. It equals (enable AND some entry eligible) as the state stood one clock earlier. After reset, all entries are invalid, the enable and mask are zero and the request is low.
- R12: Guest address 0x00 holds the interface enable in bit 0 and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hyp_addr | input | 8 | Hypervisor port byte address |
| hyp_we | input | 1 | Hypervisor write strobe |
| hyp_wdata | input | 32 | Hypervisor write data |
| hyp_rdata | output | 32 | Hypervisor read data for hyp_addr |
| gst_addr | input | 8 | Guest port byte address |
| gst_we | input | 1 | Guest write strobe |
| gst_re | input | 1 | Guest read strobe (acknowledge side effect) |
| gst_wdata | input | 32 | Guest write data |
| gst_rdata | output | 32 | Guest read data for gst_addr |
| virq_o | output | 1 | Virtual interrupt request |

## Verification
The bench sweeps dozens of priority, state and mask mixes with repeated tied priorities. It acknowledges until the bank runs dry, which shows up a picker that favours the highest index on ties, or one that treats equal-to-mask as eligible. It also exposes a picker that ignores entries in state 3, or that leaves an acknowledged entry pending, since the same ID would then come back twice. Duplicate virtual/CPU pairs catch an end-of-interrupt search that retires the wrong entry or more than one. A non-matching write catches a design that clears something anyway. The one-cycle request latency is checked at the exact edge after enabling, and acknowledges while disabled must leave the entries untouched.

// File: rtl/virq_pkg.sv
package virq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int VID_W  = 10;
    localparam int CPU_W  = 3;
    localparam int PRIO_W = 5;
    localparam int BP_W   = 3;

    localparam logic [DATA_W-1:0] NO_IRQ_ID = 32'd1023;
    localparam logic [DATA_W-1:0] TYPE_BASE = 32'h4400_0000;

    // hypervisor port map
    localparam logic [ADDR_W-1:0] H_TYPE    = 8'h04;
    localparam logic [ADDR_W-1:0] H_VMCR    = 8'h08;
    localparam logic [ADDR_W-1:0] H_EOI_LO  = 8'h20;
    localparam logic [ADDR_W-1:0] H_EOI_HI  = 8'h24;
    localparam logic [ADDR_W-1:0] H_EMPTY   = 8'h30;
    localparam logic [ADDR_W-1:0] H_ACTPRI  = 8'h40;
    localparam logic [ADDR_W-1:0] H_LR_BASE = 8'h80;

    // guest port map
    localparam logic [ADDR_W-1:0] G_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] G_PMASK = 8'h04;
    localparam logic [ADDR_W-1:0] G_ACK   = 8'h0C;
    localparam logic [ADDR_W-1:0] G_EOI   = 8'h10;

    // list entry field positions
    localparam int LR_CPU_LSB   = 10;
    localparam int LR_EOI_BIT   = 19;
    localparam int LR_PRIO_LSB  = 23;
    localparam int LR_STATE_LSB = 28;

    // machine control field positions
    localparam int VM_MASK_LSB = 27;
    localparam int VM_BP_LSB   = 21;
    localparam int VM_ABP_LSB  = 18;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'b00,
        ST_PENDING  = 2'b01,
        ST_ACTIVE   = 2'b10,
        ST_PEND_ACT = 2'b11
    } lr_state_e;

    typedef struct packed {
        lr_state_e          state;
        logic [PRIO_W-1:0]  prio;
        logic               eoi_req;
        logic [CPU_W-1:0]   cpu;
        logic [VID_W-1:0]   vid;
    } lr_entry_t;

    typedef struct packed {
        logic [PRIO_W-1:0] mask;
        logic [BP_W-1:0]   bp;
        logic [BP_W-1:0]   abp;
    } vm_ctrl_t;

    function automatic lr_entry_t lr_unpack(input logic [DATA_W-1:0] w);
        lr_entry_t e;
        e.vid     = w[VID_W-1:0];
        e.cpu     = w[LR_CPU_LSB +: CPU_W];
        e.eoi_req = w[LR_EOI_BIT];
        e.prio    = w[LR_PRIO_LSB +: PRIO_W];
        e.state   = lr_state_e'(w[LR_STATE_LSB +: 2]);
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] lr_pack(input lr_entry_t e);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VID_W-1:0]              = e.vid;
        w[LR_CPU_LSB +: CPU_W]    = e.cpu;
        w[LR_EOI_BIT]             = e.eoi_req;
        w[LR_PRIO_LSB +: PRIO_W]  = e.prio;
        w[LR_STATE_LSB +: 2]      = e.state;
        return w;
    endfunction

    function automatic vm_ctrl_t vm_unpack(input logic [DATA_W-1:0] w);
        vm_ctrl_t v;
        v.mask = w[VM_MASK_LSB +: PRIO_W];
        v.bp   = w[VM_BP_LSB +: BP_W];
        v.abp  = w[VM_ABP_LSB +: BP_W];
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] vm_pack(input vm_ctrl_t v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[VM_MASK_LSB +: PRIO_W] = v.mask;
        w[VM_BP_LSB +: BP_W]     = v.bp;
        w[VM_ABP_LSB +: BP_W]    = v.abp;
        return w;
    endfunction

    function automatic logic is_pending(input lr_state_e s);
        logic [1:0] v;
        v = s;
        return v[0];
    endfunction

endpackage

// File: rtl/virq_lr_bank.sv
module virq_lr_bank
    import virq_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     ack_fire,
    input  logic [IDX_W-1:0]         ack_idx,
    input  logic                     eoi_fire,
    input  logic [IDX_W-1:0]         eoi_idx,
    output lr_entry_t [NUM_LR-1:0]   entries
);

    // Per-entry storage; a hypervisor write to an entry wins over a guest
    // action on the same entry in the same cycle.
    for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
        lr_entry_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                q <= lr_unpack(wr_data);
            end else if (eoi_fire && eoi_idx == IDX_W'(i)) begin
                q.state <= ST_INVALID;
            end else if (ack_fire && ack_idx == IDX_W'(i)) begin
                q.state <= ST_ACTIVE;
            end
        end
        assign entries[i] = q;
    end

endmodule

// File: rtl/virq_select.sv
module virq_select
    import virq_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  lr_entry_t [NUM_LR-1:0] entries,
    input  logic [PRIO_W-1:0]      mask,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    logic [PRIO_W-1:0] best;

    // Strict compare while scanning upward keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < NUM_LR; i++) begin
            if (is_pending(entries[i].state) && entries[i].prio < mask &&
                (!found || entries[i].prio < best)) begin
                found = 1'b1;
                best  = entries[i].prio;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/virq_eoi_match.sv
module virq_eoi_match
    import virq_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  lr_entry_t [NUM_LR-1:0] entries,
    input  logic [VID_W-1:0]       vid,
    input  logic [CPU_W-1:0]       cpu,
    output logic                   found,
    output logic [IDX_W-1:0]       idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (!found && entries[i].state != ST_INVALID &&
                entries[i].vid == vid && entries[i].cpu == cpu) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/virq_list_if.sv
module virq_list_if
    import virq_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        hyp_addr,
    input  logic              hyp_we,
    input  logic [31:0]       hyp_wdata,
    output logic [31:0]       hyp_rdata,
    input  logic [7:0]        gst_addr,
    input  logic              gst_we,
    input  logic              gst_re,
    input  logic [31:0]       gst_wdata,
    output logic [31:0]       gst_rdata,
    output logic              virq_o
);

    localparam int IDX_W   = (NUM_LR > 1) ? $clog2(NUM_LR) : 1;
    localparam int LR_SPAN = 4 * NUM_LR;

    lr_entry_t [NUM_LR-1:0] entries;
    vm_ctrl_t               vm_q;
    logic                   enable_q;
    logic                   virq_q;

    // ---------------- hypervisor list-entry decode ----------------
    logic [ADDR_W:0]   lr_off;
    logic              lr_hit;
    logic [IDX_W-1:0]  lr_idx;
    logic              hyp_lr_we;

    assign lr_off    = {1'b0, hyp_addr} - {1'b0, H_LR_BASE};
    assign lr_hit    = ({1'b0, hyp_addr} >= {1'b0, H_LR_BASE}) &&
                       (lr_off < (ADDR_W+1)'(LR_SPAN)) &&
                       (hyp_addr[1:0] == 2'b00);
    assign lr_idx    = lr_off[IDX_W+1:2];
    assign hyp_lr_we = hyp_we && lr_hit;

    // ---------------- guest action decode ----------------
    logic              sel_found;
    logic [IDX_W-1:0]  sel_idx;
    logic              eoi_found;
    logic [IDX_W-1:0]  eoi_idx;
    logic              ack_fire;
    logic              eoi_fire;
    lr_entry_t         eoi_req_fields;

    assign eoi_req_fields = lr_unpack(gst_wdata);
    assign ack_fire = gst_re && (gst_addr == G_ACK) && enable_q && sel_found;
    assign eoi_fire = gst_we && (gst_addr == G_EOI) && eoi_found;

    virq_select #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_select (
        .entries (entries),
        .mask    (vm_q.mask),
        .found   (sel_found),
        .idx     (sel_idx)
    );

    virq_eoi_match #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_match (
        .entries (entries),
        .vid     (eoi_req_fields.vid),
        .cpu     (eoi_req_fields.cpu),
        .found   (eoi_found),
        .idx     (eoi_idx)
    );

    virq_lr_bank #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (hyp_lr_we),
        .wr_idx   (lr_idx),
        .wr_data  (hyp_wdata),
        .ack_fire (ack_fire),
        .ack_idx  (sel_idx),
        .eoi_fire (eoi_fire),
        .eoi_idx  (eoi_idx),
        .entries  (entries)
    );

    // ---------------- control state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            vm_q     <= '0;
            enable_q <= 1'b0;
            virq_q   <= 1'b0;
        end else begin
            if (hyp_we && hyp_addr == H_VMCR) begin
                vm_q <= vm_unpack(hyp_wdata);
            end else if (gst_we && gst_addr == G_PMASK) begin
                vm_q.mask <= gst_wdata[PRIO_W-1:0];
            end
            if (gst_we && gst_addr == G_CTRL) begin
                enable_q <= gst_wdata[0];
            end
            virq_q <= enable_q && sel_found;
        end
    end

    assign virq_o = virq_q;

    // ---------------- derived status ----------------
    logic [NUM_LR-1:0]     empty_vec;
    logic [NUM_LR-1:0]     done_vec;
    logic [2*DATA_W-1:0]   done_all;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_status
        assign empty_vec[i] = (entries[i].state == ST_INVALID);
        assign done_vec[i]  = (entries[i].state == ST_INVALID) && entries[i].eoi_req;
    end
    assign done_all = (2*DATA_W)'(done_vec);

    // ---------------- read muxes ----------------
    always_comb begin
        case (hyp_addr)
            H_TYPE:   hyp_rdata = TYPE_BASE | DATA_W'(NUM_LR - 1);
            H_VMCR:   hyp_rdata = vm_pack(vm_q);
            H_EOI_LO: hyp_rdata = done_all[DATA_W-1:0];
            H_EOI_HI: hyp_rdata = done_all[2*DATA_W-1:DATA_W];
            H_EMPTY:  hyp_rdata = DATA_W'(empty_vec);
            H_ACTPRI: hyp_rdata = '0;
            default:  hyp_rdata = lr_hit ? lr_pack(entries[lr_idx]) : '0;
        endcase
    end

    logic [DATA_W-1:0] ack_word;
    assign ack_word = (enable_q && sel_found) ?
                      DATA_W'({entries[sel_idx].cpu, entries[sel_idx].vid}) :
                      NO_IRQ_ID;

    always_comb begin
        case (gst_addr)
            G_CTRL:  gst_rdata = DATA_W'(enable_q);
            G_PMASK: gst_rdata = DATA_W'(vm_q.mask);
            G_ACK:   gst_rdata = ack_word;
            default: gst_rdata = '0;
        endcase
    end

endmodule

// File: rtl/virq_list_if_chk.sv
module virq_list_if_chk
    import virq_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int IDX_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             hyp_addr,
    input  logic                   hyp_we,
    input  logic [31:0]            hyp_rdata,
    input  logic [7:0]             gst_addr,
    input  logic                   gst_we,
    input  logic                   gst_re,
    input  logic [31:0]            gst_rdata,
    input  logic                   virq,
    input  logic                   en_q,
    input  lr_entry_t [NUM_LR-1:0] entries,
    input  logic                   sel_found,
    input  logic [IDX_W-1:0]       sel_idx,
    input  logic                   ack_fire,
    input  logic                   eoi_found
);

    logic             past_ok;
    logic [IDX_W-1:0] last_ack_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok      <= 1'b0;
            last_ack_idx <= '0;
        end else begin
            past_ok      <= 1'b1;
            last_ack_idx <= sel_idx;
        end
    end

    p_type_value_r2: assert property (@(posedge clk) disable iff (rst)
        (hyp_addr == H_TYPE) |-> (hyp_rdata == (TYPE_BASE | DATA_W'(NUM_LR - 1))));

    p_ack_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (gst_re && gst_addr == G_ACK && (!en_q || !sel_found)) |-> (gst_rdata == NO_IRQ_ID));

    p_ack_activates_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_fire && !hyp_we) |=> (entries[last_ack_idx].state == ST_ACTIVE));

    p_nomatch_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (gst_we && gst_addr == G_EOI && !eoi_found && !hyp_we) |=> $stable(entries));

    p_irq_off_disabled_r11: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(en_q)) |-> !virq);

    for (genvar i = 0; i < NUM_LR; i++) begin : g_empty
        p_empty_bits_r9: assert property (@(posedge clk) disable iff (rst)
            (hyp_addr == H_EMPTY) |-> (hyp_rdata[i] == (entries[i].state == ST_INVALID)));
    end

endmodule

bind virq_list_if virq_list_if_chk #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hyp_addr  (hyp_addr),
    .hyp_we    (hyp_we),
    .hyp_rdata (hyp_rdata),
    .gst_addr  (gst_addr),
    .gst_we    (gst_we),
    .gst_re    (gst_re),
    .gst_rdata (gst_rdata),
    .virq      (virq_o),
    .en_q      (enable_q),
    .entries   (entries),
    .sel_found (sel_found),
    .sel_idx   (sel_idx),
    .ack_fire  (ack_fire),
    .eoi_found (eoi_found)
);

// File: tb/virq_list_if_bench.sv
`timescale 1ns/1ps
module virq_list_if_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  hyp_addr = '0;
    logic        hyp_we = 1'b0;
    logic [31:0] hyp_wdata = '0;
    logic [31:0] hyp_rdata;
    logic [7:0]  gst_addr = '0;
    logic        gst_we = 1'b0;
    logic        gst_re = 1'b0;
    logic [31:0] gst_wdata = '0;
    logic [31:0] gst_rdata;
    logic        virq_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int m_state [4];
    int m_prio  [4];
    int m_vid   [4];
    int m_cpu   [4];
    int m_eoi   [4];

    always #2.5 clk = ~clk;

    virq_list_if u_virq_list_if (
        .clk(clk), .rst(rst),
        .hyp_addr(hyp_addr), .hyp_we(hyp_we), .hyp_wdata(hyp_wdata), .hyp_rdata(hyp_rdata),
        .gst_addr(gst_addr), .gst_we(gst_we), .gst_re(gst_re), .gst_wdata(gst_wdata),
        .gst_rdata(gst_rdata), .virq_o(virq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); hyp_addr = a; hyp_wdata = d; hyp_we = 1'b1;
        @(negedge clk); hyp_we = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); hyp_addr = a; #1; d = hyp_rdata;
    endtask

    task automatic gwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); gst_addr = a; gst_wdata = d; gst_we = 1'b1;
        @(negedge clk); gst_we = 1'b0;
    endtask

    task automatic gread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); gst_addr = a; #1; d = gst_rdata;
    endtask

    task automatic gack(output logic [31:0] d);
        @(negedge clk); gst_addr = 8'h0C; gst_re = 1'b1; #1; d = gst_rdata;
        @(negedge clk); gst_re = 1'b0;
    endtask

    function automatic logic [31:0] lr_word(int vid, int cpu, int eoi, int prio, int st);
        return 32'(vid) | (32'(cpu) << 10) | (32'(eoi) << 19) | (32'(prio) << 23) | (32'(st) << 28);
    endfunction

    function automatic int pick(int mask);
        int best = -1;
        for (int i = 0; i < 4; i++)
            if ((m_state[i] % 2) == 1 && m_prio[i] < mask && (best < 0 || m_prio[i] < m_prio[best]))
                best = i;
        return best;
    endfunction

    function automatic logic [31:0] model_empty();
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) if (m_state[i] == 0) v[i] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] model_done();
        logic [31:0] v = '0;
        for (int i = 0; i < 4; i++) if (m_state[i] == 0 && m_eoi[i] == 1) v[i] = 1'b1;
        return v;
    endfunction

    task automatic load_entry(int i);
        hwrite(8'h80 + 8'(4*i), lr_word(m_vid[i], m_cpu[i], m_eoi[i], m_prio[i], m_state[i]));
    endtask

    task automatic check_entries(input string req);
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            hread(8'h80 + 8'(4*i), d);
            check(req, d, lr_word(m_vid[i], m_cpu[i], m_eoi[i], m_prio[i], m_state[i]));
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int mask;
        int best;
        int j;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state (R11, R9, R2, R10, R12, R4)
        @(negedge clk); #1;
        check("R11 reset irq", 32'(virq_o), 32'd0);
        hread(8'h30, d); check("R9 reset empty", d, 32'h0000_000F);
        hread(8'h04, d); check("R2 type", d, 32'h4400_0003);
        hread(8'h40, d); check("R2 active-priority zero", d, 32'h0);
        hread(8'h20, d); check("R10 reset eoi status", d, 32'h0);
        gread(8'h00, d); check("R12 reset enable", d, 32'h0);
        gack(d);         check("R4 ack after reset", d, 32'd1023);

        // R2 writes ignored
        hwrite(8'h04, 32'h0);
        hwrite(8'h40, 32'hFFFF_FFFF);
        hread(8'h04, d); check("R2 type after write", d, 32'h4400_0003);
        hread(8'h40, d); check("R2 active-priority after write", d, 32'h0);

        // R1 field layout and readback mask
        for (int i = 0; i < 4; i++) begin
            hwrite(8'h80 + 8'(4*i), 32'hFFFF_FFFF);
            hread(8'h80 + 8'(4*i), d); check("R1 all-ones mask", d, 32'h3F88_1FFF);
            hwrite(8'h80 + 8'(4*i), lr_word(300 + i, 7 - i, i % 2, 9 + i, 2));
            hread(8'h80 + 8'(4*i), d); check("R1 pattern", d, lr_word(300 + i, 7 - i, i % 2, 9 + i, 2));
            hwrite(8'h80 + 8'(4*i), 32'h0);
        end

        // R3 machine control and shared mask
        hwrite(8'h08, (32'd19 << 27) | (32'd5 << 21) | (32'd2 << 18));
        hread(8'h08, d); check("R3 vmcr readback", d, (32'd19 << 27) | (32'd5 << 21) | (32'd2 << 18));
        gread(8'h04, d); check("R3 guest mask view", d, 32'd19);
        gwrite(8'h04, 32'd7);
        hread(8'h08, d); check("R3 vmcr after guest mask", d, (32'd7 << 27) | (32'd5 << 21) | (32'd2 << 18));

        // R4 / R11 disabled interface with eligible entry
        gwrite(8'h04, 32'd31);
        for (int i = 0; i < 4; i++) begin
            m_vid[i] = 40 + i; m_cpu[i] = i; m_eoi[i] = 0; m_prio[i] = 0; m_state[i] = 1;
            load_entry(i);
        end
        gack(d); check("R4 ack while disabled", d, 32'd1023);
        check_entries("R4 state untouched while disabled");
        check("R11 irq low while disabled", 32'(virq_o), 32'd0);

        // R12 enable, R11 exact latency
        gwrite(8'h00, 32'h1);
        #1; check("R11 irq one cycle later not yet", 32'(virq_o), 32'd0);
        @(negedge clk); #1;
        check("R11 irq raised", 32'(virq_o), 32'd1);
        gread(8'h00, d); check("R12 enable readback", d, 32'h1);

        // sweep over priorities, states and masks (R5, R6, R7, R8, R9, R10, R11)
        for (int t = 0; t < 48; t++) begin
            mask = (t % 3 == 0) ? 31 : ((t % 3 == 1) ? 16 : 8);
            gwrite(8'h04, 32'(mask));
            for (int i = 0; i < 4; i++) begin
                m_prio[i]  = ((t + i * (t % 5 + 1)) % 6) * 4;
                m_state[i] = ((t + i) % 4 == 3) ? 2 : (((t + i) % 4 == 2) ? 3 : 1);
                m_vid[i]   = t * 4 + i + 32;
                m_cpu[i]   = (t + i) % 8;
                m_eoi[i]   = (t + i) % 2;
                load_entry(i);
            end
            @(negedge clk); @(negedge clk); #1;
            check("R11 irq after load", 32'(virq_o), (pick(mask) >= 0) ? 32'd1 : 32'd0);
            for (int k = 0; k < 5; k++) begin
                best = pick(mask);
                gack(d);
                if (best >= 0) begin
                    check("R5 ack selection", d, 32'(m_vid[best]) | (32'(m_cpu[best]) << 10));
                    m_state[best] = 2;
                end else begin
                    check("R4 ack none eligible", d, 32'd1023);
                end
            end
            check_entries("R6 states after acks");
            // R8 unmatched end-of-interrupt
            gwrite(8'h10, 32'd1000 | (32'd7 << 10));
            check_entries("R8 unmatched eoi");
            // R7 retire one entry by ID pair
            j = t % 4;
            gwrite(8'h10, 32'(m_vid[j]) | (32'(m_cpu[j]) << 10));
            m_state[j] = 0;
            check_entries("R7 eoi retire");
            hread(8'h30, d); check("R9 empty bitmap", d, model_empty());
            hread(8'h20, d); check("R10 eoi status low", d, model_done());
            hread(8'h24, d); check("R10 eoi status high", d, 32'h0);
            @(negedge clk); #1;
            check("R11 irq after drain", 32'(virq_o), (pick(mask) >= 0) ? 32'd1 : 32'd0);
        end

        // R7 duplicate ID pair: lowest index retired only
        for (int i = 0; i < 4; i++) begin
            m_vid[i] = (i % 2 == 1) ? 55 : 60 + i; m_cpu[i] = (i % 2 == 1) ? 2 : 0;
            m_eoi[i] = 1; m_prio[i] = 3; m_state[i] = 2;
            load_entry(i);
        end
        gwrite(8'h10, 32'd55 | (32'd2 << 10));
        m_state[1] = 0;
        check_entries("R7 duplicate pair lowest index");
        gwrite(8'h10, 32'd55 | (32'd2 << 10));
        m_state[3] = 0;
        check_entries("R7 duplicate pair second");
        hread(8'h20, d); check("R10 eoi status after duplicates", d, 32'h0000_000A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule